// File: doc/BRIEF.md
# Event-Buffered Reactive Node Wrapper

This block wraps a reactive transition function so that it behaves as a node in a network of event-driven state machines. Each input signal has a one-place event buffer: a presence flag plus a data register. A sender strobes an input to write its value and mark it present. The flag stays set until the node consumes it. A re-emission before consumption replaces the pending value.

The wrapper runs a strict four-phase reaction cycle: idle, detect, execute, emit. In the detect phase, every presence flag and data register is copied into a snapshot in one clock edge, and the captured flags are cleared. In the execute phase, the external combinational transition function sees only that snapshot and the current node state. Its next state, output event set and output values are registered. In the emit phase, the output event strobes are raised one cycle after their data has been written.

A node reacts only when at least one input is pending. The single exception is one initial reaction after reset, which runs on an empty snapshot.

Top module: `cfsm_evbuf_node`

## Requirements
- R1: While reset is asserted, `out_ev` is all zero, `out_data` is all zero and `node_state` is zero.
- R2: After reset, exactly one reaction runs with an empty snapshot. `node_state` takes the function's next state, and no output event is raised.
- R3: With no input pending, and the initial reaction done, the node stays idle. `node_state` and `out_data` hold, and `out_ev` stays zero.
- R4: Phases run strictly idle, detect, execute, emit, idle. Detect, execute and emit each last exactly one cycle.
- R5: All presence flags and their data are captured in the same detect edge. The function inputs (`fn_in_ev`, `fn_in_data`) show only that snapshot, so values written later do not affect the running reaction.
- R6: Each captured flag is cleared at the detect edge. An emission arriving in the detect cycle, or later in the reaction, stays pending and triggers the next reaction with its own data.
- R7: Two emissions of one input before it is consumed give one reaction, which sees the later data value.
- R8: On the execute edge, each output lane flagged in `fn_out_ev` is loaded from its slice of `fn_out_data`; unflagged lanes keep their value. The `out_ev` bits of those lanes rise one cycle later and stay high for exactly one cycle. `out_data` does not change in that cycle.
- R9: Starting from idle, an input strobe sampled at clock edge E produces `out_ev` at edge E+4. Output lane k occupies bits [k*DW +: DW] of `out_data`, and input i occupies bits [i*DW +: DW] of `in_data` and `fn_in_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_emit | input | N_IN | Per-input emission strobe; writes data and sets the flag |
| in_data | input | N_IN*DW | Per-input value written with the strobe |
| fn_in_ev | output | N_IN | Snapshot of presence flags for the transition function |
| fn_in_data | output | N_IN*DW | Snapshot of input values for the transition function |
| fn_next_state | input | SW | Next state from the transition function |
| fn_out_ev | input | N_OUT | Output events chosen by the transition function |
| fn_out_data | input | N_OUT*DW | Output values from the transition function |
| out_ev | output | N_OUT | One-cycle output event strobes |
| out_data | output | N_OUT*DW | Registered output values, valid a cycle before their event |
| node_state | output | SW | Current node state, also fed to the transition function |

## Verification
The two functions that can share a cycle are consuming a buffer at the detect edge and a new emission into that same buffer. A strobe is placed exactly in the detect cycle, and another one a cycle later during execute. The bench judges the case correct only if the first reaction's outputs ignore both late strobes, and a second reaction follows that carries the late data. Re-emission before capture is driven the same way, and is judged by a single reaction carrying the later value.

// File: rtl/cfsm_evbuf_pkg.sv
package cfsm_evbuf_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_DETECT = 2'd1,
      PH_EXEC   = 2'd2,
      PH_EMIT   = 2'd3
   } phase_t;
endpackage

// File: rtl/cfsm_evslot.sv
// One-place input buffer: presence flag, data register and snapshot copy.
module cfsm_evslot #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          emit,
   input  logic [DW-1:0] wdata,
   input  logic          capture,
   output logic          flag,
   output logic          snap_flag,
   output logic [DW-1:0] snap_data
);
   logic [DW-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag      <= 1'b0;
         data_q    <= '0;
         snap_flag <= 1'b0;
         snap_data <= '0;
      end else begin
         // a new emission wins over consumption in the same edge
         if (emit) begin
            flag   <= 1'b1;
            data_q <= wdata;
         end else if (capture) begin
            flag <= 1'b0;
         end
         if (capture) begin
            snap_flag <= flag;
            snap_data <= data_q;
         end
      end
   end

   assert_clear_on_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !emit) |=> !flag);
   assert_late_event_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && emit) |=> flag);
   assert_snap_only_on_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> ($stable(snap_flag) && $stable(snap_data)));
endmodule

// File: rtl/cfsm_phase_seq.sv
// Four-phase reaction sequencer with one initial reaction after reset.
module cfsm_phase_seq
   import cfsm_evbuf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic any_pending,
   output logic capture,
   output logic exec,
   output logic emit_go
);
   phase_t phase_q;
   logic   init_pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         init_pend_q <= 1'b1;
      end else begin
         unique case (phase_q)
            PH_IDLE:   if (any_pending || init_pend_q) phase_q <= PH_DETECT;
            PH_DETECT: begin
               phase_q     <= PH_EXEC;
               init_pend_q <= 1'b0;
            end
            PH_EXEC:   phase_q <= PH_EMIT;
            PH_EMIT:   phase_q <= PH_IDLE;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   assign capture = (phase_q == PH_DETECT);
   assign exec    = (phase_q == PH_EXEC);
   assign emit_go = (phase_q == PH_EMIT);

   assert_detect_then_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> exec);
   assert_exec_then_emit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exec |=> emit_go);
   assert_emit_then_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      emit_go |=> (!capture && !exec && !emit_go));
   assert_phase_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({capture, exec, emit_go}));
   assert_quiet_stays_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE && !any_pending && !init_pend_q) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/cfsm_out_stage.sv
// Registers the transition result; events follow data by one cycle.
module cfsm_out_stage #(
   parameter int N_OUT = 2,
   parameter int DW    = 8,
   parameter int SW    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                exec,
   input  logic                emit_go,
   input  logic [SW-1:0]       fn_next_state,
   input  logic [N_OUT-1:0]    fn_out_ev,
   input  logic [N_OUT*DW-1:0] fn_out_data,
   output logic [N_OUT-1:0]    out_ev,
   output logic [N_OUT*DW-1:0] out_data,
   output logic [SW-1:0]       node_state
);
   logic [N_OUT-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         node_state <= '0;
         pend_q     <= '0;
         out_ev     <= '0;
      end else begin
         if (exec) begin
            node_state <= fn_next_state;
            pend_q     <= fn_out_ev;
         end
         out_ev <= emit_go ? pend_q : '0;
      end
   end

   for (genvar k = 0; k < N_OUT; k++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) out_data[k*DW +: DW] <= '0;
         else if (exec && fn_out_ev[k]) out_data[k*DW +: DW] <= fn_out_data[k*DW +: DW];
      end
   end

   assert_data_before_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_ev) |-> $stable(out_data));
   assert_event_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_ev) |=> (out_ev == '0));
   assert_event_needs_emit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_ev) |-> $past(emit_go));
endmodule

// File: rtl/cfsm_evbuf_node.sv
module cfsm_evbuf_node
   import cfsm_evbuf_pkg::*;
#(
   parameter int N_IN  = 3,
   parameter int N_OUT = 2,
   parameter int DW    = 8,
   parameter int SW    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_IN-1:0]     in_emit,
   input  logic [N_IN*DW-1:0]  in_data,
   output logic [N_IN-1:0]     fn_in_ev,
   output logic [N_IN*DW-1:0]  fn_in_data,
   input  logic [SW-1:0]       fn_next_state,
   input  logic [N_OUT-1:0]    fn_out_ev,
   input  logic [N_OUT*DW-1:0] fn_out_data,
   output logic [N_OUT-1:0]    out_ev,
   output logic [N_OUT*DW-1:0] out_data,
   output logic [SW-1:0]       node_state
);
   if (N_IN < 1)  begin : g_bad_nin  $error("N_IN must be at least 1");  end
   if (N_OUT < 1) begin : g_bad_nout $error("N_OUT must be at least 1"); end
   if (DW < 1)    begin : g_bad_dw   $error("DW must be at least 1");    end
   if (SW < 1)    begin : g_bad_sw   $error("SW must be at least 1");    end

   logic [N_IN-1:0] flags;
   logic capture, exec, emit_go;

   for (genvar i = 0; i < N_IN; i++) begin : g_slot
      cfsm_evslot #(.DW(DW)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .emit      (in_emit[i]),
         .wdata     (in_data[i*DW +: DW]),
         .capture   (capture),
         .flag      (flags[i]),
         .snap_flag (fn_in_ev[i]),
         .snap_data (fn_in_data[i*DW +: DW])
      );
   end

   cfsm_phase_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .any_pending (|flags),
      .capture     (capture),
      .exec        (exec),
      .emit_go     (emit_go)
   );

   cfsm_out_stage #(.N_OUT(N_OUT), .DW(DW), .SW(SW)) u_out (
      .clk           (clk),
      .rst_n         (rst_n),
      .exec          (exec),
      .emit_go       (emit_go),
      .fn_next_state (fn_next_state),
      .fn_out_ev     (fn_out_ev),
      .fn_out_data   (fn_out_data),
      .out_ev        (out_ev),
      .out_data      (out_data),
      .node_state    (node_state)
   );

   assert_state_moves_only_in_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !exec |=> $stable(node_state));
   assert_snapshot_held_through_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      emit_go |-> ($stable(fn_in_ev) && $stable(fn_in_data)));
endmodule

// File: tb/sim_cfsm_evbuf_node.sv
module sim_cfsm_evbuf_node;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic [2:0]  in_emit;
   logic [23:0] in_data;
   logic [2:0]  fn_in_ev;
   logic [23:0] fn_in_data;
   logic [3:0]  fn_next_state;
   logic [1:0]  fn_out_ev;
   logic [15:0] fn_out_data;
   logic [1:0]  out_ev;
   logic [15:0] out_data;
   logic [3:0]  node_state;

   cfsm_evbuf_node #(.N_IN(3), .N_OUT(2), .DW(8), .SW(4)) u0 (.*);

   // bench transition function: counter state, lane0 = sum of in0/in1, lane1 = in2 ^ state
   assign fn_next_state = node_state + 4'd1;
   assign fn_out_ev     = {fn_in_ev[2], fn_in_ev[0] | fn_in_ev[1]};
   assign fn_out_data[7:0]  = (fn_in_ev[0] ? fn_in_data[7:0] : 8'd0)
                            + (fn_in_ev[1] ? fn_in_data[15:8] : 8'd0);
   assign fn_out_data[15:8] = fn_in_data[23:16] ^ {4'd0, node_state};

   int checks = 0, errors = 0, pulse_cnt = 0;
   logic [3:0] exp_state = 4'd0;
   logic [7:0] exp_d0 = 8'd0, exp_d1 = 8'd0;

   always @(negedge clk) if (rst_n === 1'b1 && |out_ev) pulse_cnt++;
   always @(posedge clk) #1 in_emit <= 3'b000;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put(int idx, logic [7:0] v);
      in_emit[idx] = 1'b1;
      in_data[idx*8 +: 8] = v;
   endtask

   task automatic wait_pulse(output logic [1:0] ev, output logic [15:0] d,
                             output logic [15:0] dprev, output int n);
      n = 0;
      dprev = out_data;
      do begin
         dprev = out_data;
         @(negedge clk);
         n++;
      end while (out_ev == 2'b00 && n < 40);
      ev = out_ev;
      d  = out_data;
   endtask

   task automatic t_reset;
      rst_n = 1'b0; in_emit = '0; in_data = '0;
      repeat (3) @(negedge clk);
      chk("R1", "out_ev in reset", out_ev, 0);
      chk("R1", "out_data in reset", out_data, 0);
      chk("R1", "node_state in reset", node_state, 0);
   endtask

   task automatic t_initial;
      rst_n = 1'b1;
      repeat (8) @(negedge clk);
      exp_state = 4'd1;
      chk("R2", "state after initial reaction", node_state, exp_state);
      chk("R2", "no output events on initial reaction", pulse_cnt, 0);
   endtask

   task automatic t_quiet;
      logic [15:0] d0 = out_data;
      repeat (20) @(negedge clk);
      chk("R3", "state holds with no input", node_state, exp_state);
      chk("R3", "no pulses while quiet", pulse_cnt, 0);
      chk("R3", "data holds while quiet", out_data, d0);
   endtask

   task automatic t_single;
      logic [1:0] ev; logic [15:0] d, dp; int n;
      put(0, 8'd5);
      wait_pulse(ev, d, dp, n);
      exp_d0 = 8'd5; exp_state++;
      chk("R9", "latency in negedges after strobe", n, 5);
      chk("R8", "single event lanes", ev, 2'b01);
      chk("R8", "lane0 data", d[7:0], exp_d0);
      chk("R8", "data valid cycle before event", dp, d);
      chk("R8", "unflagged lane1 kept", d[15:8], exp_d1);
      @(negedge clk);
      chk("R8", "event lasts one cycle", out_ev, 0);
      chk("R2", "state after single", node_state, exp_state);
   endtask

   task automatic t_pair;
      logic [1:0] ev; logic [15:0] d, dp; int n;
      put(0, 8'd10); put(1, 8'd20);
      wait_pulse(ev, d, dp, n);
      exp_d0 = 8'd30; exp_state++;
      chk("R5", "both inputs in one snapshot", d[7:0], exp_d0);
      chk("R5", "pair events", ev, 2'b01);
      @(negedge clk);
   endtask

   task automatic t_held;
      logic [1:0] ev; logic [15:0] d, dp; int n, base;
      base = pulse_cnt;
      put(0, 8'd7);
      @(negedge clk);
      @(negedge clk); put(2, 8'h55);   // lands on the detect edge
      @(negedge clk); put(0, 8'd99);   // lands on the execute edge
      wait_pulse(ev, d, dp, n);
      exp_d0 = 8'd7; exp_state++;
      chk("R5", "first reaction ignores late data", d[7:0], exp_d0);
      chk("R6", "first reaction lanes", ev, 2'b01);
      @(negedge clk);
      wait_pulse(ev, d, dp, n);
      exp_d0 = 8'd99; exp_d1 = 8'h55 ^ {4'd0, exp_state}; exp_state++;
      chk("R6", "held events react next", ev, 2'b11);
      chk("R6", "held lane0 data", d[7:0], exp_d0);
      chk("R6", "held lane1 data", d[15:8], exp_d1);
      @(negedge clk);
      chk("R6", "two reactions total", pulse_cnt - base, 2);
   endtask

   task automatic t_overwrite;
      logic [1:0] ev; logic [15:0] d, dp; int n, base;
      base = pulse_cnt;
      put(1, 8'd3);
      @(negedge clk); put(1, 8'd9);
      wait_pulse(ev, d, dp, n);
      exp_d0 = 8'd9; exp_state++;
      chk("R7", "later value wins", d[7:0], exp_d0);
      repeat (15) @(negedge clk);
      chk("R7", "single reaction for two strobes", pulse_cnt - base, 1);
      chk("R7", "state after overwrite", node_state, exp_state);
   endtask

   task automatic t_keep;
      logic [1:0] ev; logic [15:0] d, dp; int n;
      put(2, 8'h20);
      wait_pulse(ev, d, dp, n);
      exp_d1 = 8'h20 ^ {4'd0, exp_state}; exp_state++;
      chk("R8", "lane1 only", ev, 2'b10);
      chk("R8", "lane0 kept", d[7:0], exp_d0);
      chk("R8", "lane1 data", d[15:8], exp_d1);
      chk("R9", "latency lane1", n, 5);
      @(negedge clk);
   endtask

   bit finished = 0;
   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 100000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      t_reset();
      t_initial();
      t_quiet();
      t_single();
      t_pair();
      t_held();
      t_overwrite();
      t_keep();
      finish_run();
   end
endmodule